// File: doc/BRIEF.md
# Half-rate synchronous command bridge

This block joins a DMA engine clocked on a fast clock to a memory controller clocked at exactly half that rate. Both clocks come from one source and are phase-aligned, so the block runs entirely on the fast clock. The relation between the two domains is fixed at 2:1, so no asynchronous crossing is needed. The block produces a phase enable, `ph_en`, that is high in every fast cycle whose closing edge coincides with a rising slow-clock edge. Every signal that faces the controller is moved or sampled only at those edges.

Four independent valid/ready channels cross the boundary. Towards the controller there is a command channel and a write-data channel. Towards the DMA there is a response channel and a read-data channel. Back-pressure rules are as follows. A transfer on a DMA-facing channel occurs on a fast edge where valid and ready are both high. A transfer on a controller-facing channel occurs only on an edge that closes an enable-high cycle where valid and ready are both high. On both sides a sender keeps its word and valid unchanged until that transfer happens. The channels are not aligned with one another: a command and its write data may reach the controller in different slow cycles, and the receiver pairs them by handshake order. The command width and the data width are parameters, and the handshake timing does not depend on either.

The `phase_align` input restarts the enable pattern so that it lines up with a known slow-clock edge.

Top module: `ratio_bridge`

## Requirements
- R1: In the first cycle after synchronous reset is released, `ph_en` is 1, all four valid outputs are 0, and the four ready outputs (`dma_cmd_ready`, `dma_wr_ready`, `ctl_rsp_ready`, `ctl_rd_ready`) are 1.
- R2: `ph_en` is 1 in the first cycle after reset and then inverts every cycle. A cycle in which `phase_align` is 1 is always followed by a cycle in which `ph_en` is 1.
- R3: `ctl_cmd_valid`, `ctl_cmd`, `ctl_wr_valid` and `ctl_wr_data` change only on edges that close a cycle with `ph_en` = 1, so each value is held for a whole slow period.
- R4: A controller-facing word stays valid and unchanged until `ctl_*_ready` is 1 in a cycle with `ph_en` = 1. Every word accepted from the DMA reaches the controller exactly once and in the order it was accepted.
- R5: `ctl_rsp_ready` and `ctl_rd_ready` change only on edges that close a cycle with `ph_en` = 1. A controller word is taken once for each enable-high cycle in which its valid and ready are both 1, even though it is held for two fast cycles. It is then offered to the DMA once, in order, and with the DMA ready held high it appears as a single-cycle valid pulse.
- R6: Controller-side valid inputs that are high only in a cycle with `ph_en` = 0 are ignored, and no word reaches the DMA because of them.
- R7: While the DMA holds `dma_rsp_ready` low, `dma_rsp_valid` and `dma_rsp` stay unchanged. At most two words are buffered per slow-to-fast channel. `ctl_rsp_ready` falls once the buffer can take no more, and no word is lost.
- R8: The channels are independent. With `ctl_wr_ready` held low, commands still reach the controller, and the write data follows once it is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock (twice the controller clock) |
| rst | input | 1 | Synchronous reset, active high |
| phase_align | input | 1 | Next cycle is an enable-high cycle |
| ph_en | output | 1 | High in cycles closed by a slow-clock rising edge |
| dma_cmd_valid | input | 1 | DMA command valid |
| dma_cmd_ready | output | 1 | Bridge can take a DMA command |
| dma_cmd | input | CMD_W | DMA command word |
| dma_wr_valid | input | 1 | DMA write data valid |
| dma_wr_ready | output | 1 | Bridge can take write data |
| dma_wr_data | input | DATA_W | DMA write data word |
| ctl_cmd_valid | output | 1 | Command valid towards the controller |
| ctl_cmd_ready | input | 1 | Controller takes the command |
| ctl_cmd | output | CMD_W | Command word towards the controller |
| ctl_wr_valid | output | 1 | Write data valid towards the controller |
| ctl_wr_ready | input | 1 | Controller takes the write data |
| ctl_wr_data | output | DATA_W | Write data towards the controller |
| ctl_rsp_valid | input | 1 | Controller response valid |
| ctl_rsp_ready | output | 1 | Bridge can take a response |
| ctl_rsp | input | CMD_W | Controller response word |
| ctl_rd_valid | input | 1 | Controller read data valid |
| ctl_rd_ready | output | 1 | Bridge can take read data |
| ctl_rd_data | input | DATA_W | Controller read data word |
| dma_rsp_valid | output | 1 | Response valid towards the DMA |
| dma_rsp_ready | input | 1 | DMA takes the response |
| dma_rsp | output | CMD_W | Response word towards the DMA |
| dma_rd_valid | output | 1 | Read data valid towards the DMA |
| dma_rd_ready | input | 1 | DMA takes the read data |
| dma_rd_data | output | DATA_W | Read data word towards the DMA |

## Verification
Several properties are checked on every cycle: that `ph_en` alternates and obeys `phase_align`, that controller-facing words and ready outputs move only at enable-closing edges, that a controller-facing word is held until it is taken, and that a stalled DMA-facing word is held. Other behaviours can only be shown by the bench's scenarios: exactly-once in-order delivery on all four channels, rejection of a valid that appears only in a disabled cycle, the two-word limit under DMA stall, and channel independence when one controller ready is held low.

// File: rtl/ratio_bridge_pkg.sv
`timescale 1ns/1ps
package ratio_bridge_pkg;
  localparam int unsigned CMD_W_DEFAULT  = 32;
  localparam int unsigned DATA_W_DEFAULT = 64;
  // slots per slow-to-fast channel; two keeps one word per slow cycle
  localparam int unsigned S2F_DEPTH      = 2;
endpackage

// File: rtl/rb_phase_gen.sv
`timescale 1ns/1ps
module rb_phase_gen (
  input  logic clk,
  input  logic rst,
  input  logic phase_align,
  output logic en
);
  logic en_q;

  always_ff @(posedge clk) begin
    if (rst || phase_align) en_q <= 1'b1;
    else                    en_q <= ~en_q;
  end

  assign en = en_q;
endmodule

// File: rtl/rb_f2s_chan.sv
`timescale 1ns/1ps
module rb_f2s_chan #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic         stage_v;
  logic [W-1:0] stage_d;
  logic         hold_v;
  logic [W-1:0] hold_d;
  logic         accept;
  logic         advance;

  assign in_ready = ~stage_v;
  assign accept   = in_valid & ~stage_v;
  // slow-facing register may reload only at a slow edge and when free or taken
  assign advance  = en & (~hold_v | out_ready);

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_v <= 1'b0;
      hold_v  <= 1'b0;
    end else begin
      if (accept)       stage_v <= 1'b1;
      else if (advance) stage_v <= 1'b0;
      if (advance)      hold_v  <= stage_v;
    end
  end

  always_ff @(posedge clk) begin
    if (accept)             stage_d <= in_data;
    if (advance && stage_v) hold_d  <= stage_d;
  end

  assign out_valid = hold_v;
  assign out_data  = hold_d;
endmodule

// File: rtl/rb_s2f_chan.sv
`timescale 1ns/1ps
module rb_s2f_chan #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot [DEPTH];
  logic [CNT_W-1:0] fill;
  logic [CNT_W-1:0] fill_n;
  logic [CNT_W-1:0] wr_idx;
  logic             rdy_q;
  logic             take;
  logic             pop;

  assign take   = en & in_valid & rdy_q;
  assign pop    = (fill != '0) & out_ready;
  assign fill_n = fill + CNT_W'(take) - CNT_W'(pop);
  assign wr_idx = fill - CNT_W'(pop);

  always_ff @(posedge clk) begin
    if (rst) begin
      fill  <= '0;
      rdy_q <= 1'b1;
    end else begin
      fill <= fill_n;
      // promise space for the next slow edge; only pops happen in between
      if (en) rdy_q <= (fill_n < CNT_W'(DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < DEPTH - 1; k++) begin
      if (pop) slot[k] <= slot[k+1];
    end
    for (int k = 0; k < DEPTH; k++) begin
      if (take && wr_idx == CNT_W'(k)) slot[k] <= in_data;
    end
  end

  assign in_ready  = rdy_q;
  assign out_valid = (fill != '0);
  assign out_data  = slot[0];
endmodule

// File: rtl/ratio_bridge.sv
`timescale 1ns/1ps
module ratio_bridge
  import ratio_bridge_pkg::*;
#(
  parameter int unsigned CMD_W  = CMD_W_DEFAULT,
  parameter int unsigned DATA_W = DATA_W_DEFAULT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phase_align,
  output logic              ph_en,
  input  logic              dma_cmd_valid,
  output logic              dma_cmd_ready,
  input  logic [CMD_W-1:0]  dma_cmd,
  input  logic              dma_wr_valid,
  output logic              dma_wr_ready,
  input  logic [DATA_W-1:0] dma_wr_data,
  output logic              ctl_cmd_valid,
  input  logic              ctl_cmd_ready,
  output logic [CMD_W-1:0]  ctl_cmd,
  output logic              ctl_wr_valid,
  input  logic              ctl_wr_ready,
  output logic [DATA_W-1:0] ctl_wr_data,
  input  logic              ctl_rsp_valid,
  output logic              ctl_rsp_ready,
  input  logic [CMD_W-1:0]  ctl_rsp,
  input  logic              ctl_rd_valid,
  output logic              ctl_rd_ready,
  input  logic [DATA_W-1:0] ctl_rd_data,
  output logic              dma_rsp_valid,
  input  logic              dma_rsp_ready,
  output logic [CMD_W-1:0]  dma_rsp,
  output logic              dma_rd_valid,
  input  logic              dma_rd_ready,
  output logic [DATA_W-1:0] dma_rd_data
);
  logic en;

  rb_phase_gen u_phase (
    .clk(clk), .rst(rst), .phase_align(phase_align), .en(en)
  );
  assign ph_en = en;

  rb_f2s_chan #(.W(CMD_W)) u_cmd_down (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(dma_cmd_valid), .in_ready(dma_cmd_ready), .in_data(dma_cmd),
    .out_valid(ctl_cmd_valid), .out_ready(ctl_cmd_ready), .out_data(ctl_cmd)
  );

  rb_f2s_chan #(.W(DATA_W)) u_wr_down (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(dma_wr_valid), .in_ready(dma_wr_ready), .in_data(dma_wr_data),
    .out_valid(ctl_wr_valid), .out_ready(ctl_wr_ready), .out_data(ctl_wr_data)
  );

  rb_s2f_chan #(.W(CMD_W), .DEPTH(S2F_DEPTH)) u_rsp_up (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(ctl_rsp_valid), .in_ready(ctl_rsp_ready), .in_data(ctl_rsp),
    .out_valid(dma_rsp_valid), .out_ready(dma_rsp_ready), .out_data(dma_rsp)
  );

  rb_s2f_chan #(.W(DATA_W), .DEPTH(S2F_DEPTH)) u_rd_up (
    .clk(clk), .rst(rst), .en(en),
    .in_valid(ctl_rd_valid), .in_ready(ctl_rd_ready), .in_data(ctl_rd_data),
    .out_valid(dma_rd_valid), .out_ready(dma_rd_ready), .out_data(dma_rd_data)
  );
endmodule

// File: rtl/ratio_bridge_chk.sv
`timescale 1ns/1ps
module ratio_bridge_chk #(
  parameter int unsigned CMD_W  = 32,
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              phase_align,
  input logic              ph_en,
  input logic              dma_cmd_valid,
  input logic              dma_cmd_ready,
  input logic [CMD_W-1:0]  dma_cmd,
  input logic              dma_wr_valid,
  input logic              dma_wr_ready,
  input logic [DATA_W-1:0] dma_wr_data,
  input logic              ctl_cmd_valid,
  input logic              ctl_cmd_ready,
  input logic [CMD_W-1:0]  ctl_cmd,
  input logic              ctl_wr_valid,
  input logic              ctl_wr_ready,
  input logic [DATA_W-1:0] ctl_wr_data,
  input logic              ctl_rsp_valid,
  input logic              ctl_rsp_ready,
  input logic [CMD_W-1:0]  ctl_rsp,
  input logic              ctl_rd_valid,
  input logic              ctl_rd_ready,
  input logic [DATA_W-1:0] ctl_rd_data,
  input logic              dma_rsp_valid,
  input logic              dma_rsp_ready,
  input logic [CMD_W-1:0]  dma_rsp,
  input logic              dma_rd_valid,
  input logic              dma_rd_ready,
  input logic [DATA_W-1:0] dma_rd_data
);
  logic started = 1'b0;
  logic live    = 1'b0;

  always_ff @(posedge clk) begin
    started <= 1'b1;
    live    <= ~rst;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    (started && $past(rst) && !rst) |->
      (ph_en && !ctl_cmd_valid && !ctl_wr_valid && !dma_rsp_valid && !dma_rd_valid));

  // R2
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(phase_align)) |-> (ph_en != $past(ph_en)));

  // R2
  phase_align_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(phase_align)) |-> ph_en);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(ph_en)) |-> ($stable(ctl_cmd_valid) && $stable(ctl_cmd)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(ph_en)) |-> ($stable(ctl_wr_valid) && $stable(ctl_wr_data)));

  // R4
  cmd_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_cmd_valid && !(ph_en && ctl_cmd_ready)) |=> (ctl_cmd_valid && $stable(ctl_cmd)));

  // R4
  wr_wait_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_valid && !(ph_en && ctl_wr_ready)) |=> (ctl_wr_valid && $stable(ctl_wr_data)));

  // R5
  up_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (live && !$past(ph_en)) |-> ($stable(ctl_rsp_ready) && $stable(ctl_rd_ready)));

  // R7
  dma_rsp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_rsp_valid && !dma_rsp_ready) |=> (dma_rsp_valid && $stable(dma_rsp)));

  // R7
  dma_rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (dma_rd_valid && !dma_rd_ready) |=> (dma_rd_valid && $stable(dma_rd_data)));
endmodule

bind ratio_bridge ratio_bridge_chk #(.CMD_W(CMD_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/ratio_bridge_bench.sv
`timescale 1ns/1ps
module ratio_bridge_bench;
  localparam int CW = 32;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, phase_align = 1'b0, ph_en;
  logic dma_cmd_valid = 1'b0, dma_cmd_ready; logic [CW-1:0] dma_cmd = '0;
  logic dma_wr_valid = 1'b0, dma_wr_ready;   logic [DW-1:0] dma_wr_data = '0;
  logic ctl_cmd_valid, ctl_cmd_ready = 1'b1;  logic [CW-1:0] ctl_cmd;
  logic ctl_wr_valid, ctl_wr_ready = 1'b1;    logic [DW-1:0] ctl_wr_data;
  logic ctl_rsp_valid = 1'b0, ctl_rsp_ready; logic [CW-1:0] ctl_rsp = '0;
  logic ctl_rd_valid = 1'b0, ctl_rd_ready;   logic [DW-1:0] ctl_rd_data = '0;
  logic dma_rsp_valid, dma_rsp_ready = 1'b1;  logic [CW-1:0] dma_rsp;
  logic dma_rd_valid, dma_rd_ready = 1'b1;    logic [DW-1:0] dma_rd_data;

  ratio_bridge u_ratio_bridge (.*);

  int errs = 0, checks = 0;
  int n_cmd = 0, n_wr = 0, n_rsp = 0, n_rd = 0;
  logic [CW-1:0] q_cmd[$], q_rsp[$];
  logic [DW-1:0] q_wr[$], q_rd[$];
  int cmd_mode = 0, wr_mode = 0, up_mode = 0;  // 0 ready, 1 random, 2 stalled
  logic en_m = 1'b1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  // phase model from R2
  always @(posedge clk) en_m <= (rst || phase_align) ? 1'b1 : ~en_m;

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      chk(ph_en == en_m, "R2 phase enable", 64'(ph_en), 64'(en_m));
      if (en_m && ctl_cmd_valid && ctl_cmd_ready) begin
        if (q_cmd.size() == 0) chk(0, "R4 unexpected command", 64'(ctl_cmd), 0);
        else begin chk(ctl_cmd == q_cmd[0], "R4 command order", 64'(ctl_cmd), 64'(q_cmd[0])); void'(q_cmd.pop_front()); end
        n_cmd++;
      end
      if (en_m && ctl_wr_valid && ctl_wr_ready) begin
        if (q_wr.size() == 0) chk(0, "R4 unexpected write data", ctl_wr_data, 0);
        else begin chk(ctl_wr_data == q_wr[0], "R4 write data order", ctl_wr_data, q_wr[0]); void'(q_wr.pop_front()); end
        n_wr++;
      end
      if (dma_rsp_valid && dma_rsp_ready) begin
        if (q_rsp.size() == 0) chk(0, "R5 R6 unexpected response", 64'(dma_rsp), 0);
        else begin chk(dma_rsp == q_rsp[0], "R5 response order", 64'(dma_rsp), 64'(q_rsp[0])); void'(q_rsp.pop_front()); end
        n_rsp++;
      end
      if (dma_rd_valid && dma_rd_ready) begin
        if (q_rd.size() == 0) chk(0, "R5 R6 unexpected read data", dma_rd_data, 0);
        else begin chk(dma_rd_data == q_rd[0], "R5 read data order", dma_rd_data, q_rd[0]); void'(q_rd.pop_front()); end
        n_rd++;
      end
    end
  end

  // controller ready model: changes only after slow edges
  initial forever begin
    @(negedge clk);
    if (en_m) begin
      @(posedge clk); #1;
      ctl_cmd_ready = (cmd_mode == 0) ? 1'b1 : (cmd_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
      ctl_wr_ready  = (wr_mode == 0)  ? 1'b1 : (wr_mode == 1)  ? 1'($urandom_range(0, 1)) : 1'b0;
    end
  end

  // DMA ready model
  initial forever begin
    @(posedge clk); #1;
    dma_rsp_ready = (up_mode == 0) ? 1'b1 : (up_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b0;
    dma_rd_ready  = (up_mode == 2) ? 1'b1 : (up_mode == 1) ? 1'($urandom_range(0, 1)) : 1'b1;
  end

  task automatic send_cmd(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      dma_cmd_valid = 1'b1; dma_cmd = CW'(base + i);
      @(negedge clk); while (!dma_cmd_ready) @(negedge clk);
      q_cmd.push_back(CW'(base + i));
      @(posedge clk); #1; dma_cmd_valid = 1'b0;
    end
  endtask

  task automatic send_wr(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      dma_wr_valid = 1'b1; dma_wr_data = {32'(base), 32'(i)};
      @(negedge clk); while (!dma_wr_ready) @(negedge clk);
      q_wr.push_back({32'(base), 32'(i)});
      @(posedge clk); #1; dma_wr_valid = 1'b0;
    end
  endtask

  task automatic slow_boundary();
    @(negedge clk); while (!en_m) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic send_rsp(input int n, input int base);
    slow_boundary();
    for (int i = 0; i < n; ) begin
      ctl_rsp_valid = 1'b1; ctl_rsp = CW'(base + i);
      @(negedge clk); while (!en_m) @(negedge clk);
      if (ctl_rsp_ready) begin q_rsp.push_back(CW'(base + i)); i++; end
      @(posedge clk); #1;
    end
    ctl_rsp_valid = 1'b0;
  endtask

  task automatic send_rd(input int n, input int base);
    slow_boundary();
    for (int i = 0; i < n; ) begin
      ctl_rd_valid = 1'b1; ctl_rd_data = {32'(base), 32'(i)};
      @(negedge clk); while (!en_m) @(negedge clk);
      if (ctl_rd_ready) begin q_rd.push_back({32'(base), 32'(i)}); i++; end
      @(posedge clk); #1;
    end
    ctl_rd_valid = 1'b0;
  endtask

  task automatic drain(input string tag);
    repeat (30) @(posedge clk);
    @(negedge clk);
    chk(q_cmd.size() == 0 && q_wr.size() == 0, {tag, " R4 downstream drained"}, 64'(q_cmd.size() + q_wr.size()), 0);
    chk(q_rsp.size() == 0 && q_rd.size() == 0, {tag, " R5 upstream drained"}, 64'(q_rsp.size() + q_rd.size()), 0);
    @(posedge clk); #1;
  endtask

  initial begin
    #(20000 * 5);
    chk(0, "watchdog expired", 0, 1);
    summary();
  end

  initial begin
    int c0, w0, r0, d0;
    bit seen_low;
    repeat (4) @(posedge clk); #1 rst = 1'b0;
    @(negedge clk);
    // R1
    chk(ph_en == 1'b1, "R1 phase after reset", 64'(ph_en), 1);
    chk({ctl_cmd_valid, ctl_wr_valid, dma_rsp_valid, dma_rd_valid} == 4'b0, "R1 valids after reset",
        64'({ctl_cmd_valid, ctl_wr_valid, dma_rsp_valid, dma_rd_valid}), 0);
    chk({dma_cmd_ready, dma_wr_ready, ctl_rsp_ready, ctl_rd_ready} == 4'hf, "R1 readies after reset",
        64'({dma_cmd_ready, dma_wr_ready, ctl_rsp_ready, ctl_rd_ready}), 64'hf);
    @(posedge clk); #1;

    // R4: streaming with controller always ready
    c0 = n_cmd;
    fork send_cmd(8, 'h100); send_wr(8, 'h200); join
    drain("stream");
    chk(n_cmd == c0 + 8, "R4 command count", 64'(n_cmd), 64'(c0 + 8));

    // R3 R4: random controller back-pressure
    cmd_mode = 1; wr_mode = 1;
    fork send_cmd(16, 'h300); send_wr(16, 'h400); join
    cmd_mode = 0; wr_mode = 0;
    drain("random");

    // R8: write-data stalled, commands still flow
    wr_mode = 2; c0 = n_cmd; w0 = n_wr;
    fork send_cmd(4, 'h500); send_wr(4, 'h600); join_none
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(n_cmd == c0 + 4, "R8 commands pass stalled data", 64'(n_cmd), 64'(c0 + 4));
    chk(n_wr == w0, "R8 data waits for ready", 64'(n_wr), 64'(w0));
    @(posedge clk); #1; wr_mode = 0;
    wait fork;
    drain("independent");
    chk(n_wr == w0 + 4, "R8 data released", 64'(n_wr), 64'(w0 + 4));

    // R5: slow-to-fast, each held word taken once
    r0 = n_rsp; d0 = n_rd;
    fork send_rsp(8, 'h700); send_rd(8, 'h800); join
    drain("upstream");
    chk(n_rsp == r0 + 8, "R5 response count", 64'(n_rsp), 64'(r0 + 8));
    chk(n_rd == d0 + 8, "R5 read count", 64'(n_rd), 64'(d0 + 8));

    // R7: DMA stall on responses
    up_mode = 2; r0 = n_rsp; seen_low = 0;
    fork send_rsp(5, 'h900); join_none
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (!ctl_rsp_ready) seen_low = 1;
    end
    chk(seen_low, "R7 ready falls under stall", 64'(seen_low), 1);
    chk(n_rsp == r0, "R7 nothing delivered under stall", 64'(n_rsp), 64'(r0));
    chk(q_rsp.size() == 2, "R7 two words buffered", 64'(q_rsp.size()), 2);
    chk(dma_rsp_valid && dma_rsp == CW'('h900), "R7 head word held", 64'(dma_rsp), 64'h900);
    @(posedge clk); #1; up_mode = 0;
    wait fork;
    drain("stall");
    chk(n_rsp == r0 + 5, "R7 no word lost", 64'(n_rsp), 64'(r0 + 5));

    // all channels at once, random ready everywhere
    cmd_mode = 1; wr_mode = 1; up_mode = 1;
    fork send_cmd(12, 'ha00); send_wr(12, 'hb00); send_rsp(12, 'hc00); send_rd(12, 'hd00); join
    cmd_mode = 0; wr_mode = 0; up_mode = 0;
    drain("mixed");

    // R6: valid only in a disabled cycle
    r0 = n_rsp; d0 = n_rd;
    slow_boundary();
    ctl_rsp_valid = 1'b1; ctl_rsp = 'hdead; ctl_rd_valid = 1'b1; ctl_rd_data = 'hbeef;
    @(posedge clk); #1;
    ctl_rsp_valid = 1'b0; ctl_rd_valid = 1'b0;
    repeat (12) @(posedge clk);
    @(negedge clk);
    chk(n_rsp == r0 && !dma_rsp_valid, "R6 response glitch ignored", 64'(n_rsp), 64'(r0));
    chk(n_rd == d0 && !dma_rd_valid, "R6 read glitch ignored", 64'(n_rd), 64'(d0));

    // R2: realign inside an enable-high cycle
    while (en_m) @(negedge clk);
    @(posedge clk); #1;
    phase_align = 1'b1;
    @(posedge clk); #1;
    phase_align = 1'b0;
    @(negedge clk);
    chk(ph_en == 1'b1, "R2 enable after align", 64'(ph_en), 1);
    @(posedge clk); #1;
    fork send_cmd(4, 'he00); send_wr(4, 'hf00); send_rsp(4, 'h1000); send_rd(4, 'h1100); join
    drain("realigned");

    summary();
  end
endmodule